// File: doc/BRIEF.md
# Byte-Deferred Tuning Register Interface

This block is the register side of a frequency synthesizer's serial port. A front end, not part of this block, shifts in 16-bit command words and presents each one with a one-cycle valid strobe. The block keeps a 32-bit frequency tuning word and a small set of control and status flags. It also gates a DAC code supplied from outside.

A frequency write carries only eight data bits. Bytes therefore first land in a 16-bit staging buffer, and the buffer also remembers which half-word was addressed last. One opcode only stages a byte. The other stages a byte and then copies the whole 16-bit buffer into the addressed half of the tuning word in the same operation. The buffer keeps its contents between commands, so software can change a single byte of a half-word with one committing write.

A control command sets or clears the sleep and reset flags. Its clear request hands register selection to external pins by raising the sync and select-source status bits. The clear request then drops by itself after one cycle. While the reset flag is set, the reported DAC code is held at midscale.

Top module: `tuning_word_if`

## Requirements
- R1: After global reset (rst_n low), tune_word is 0, the staging buffer and the half-word pointer are 0, sleep_o and reset_o are 1, and sync_o, selsrc_o and clr_o are 0.
- R2: A valid word with D15..D12 = 4'b0011 stores D7..D0 into the staging buffer only. tune_word does not change on the following cycle.
- R3: A valid word with D15..D12 = 4'b0010 first merges D7..D0 into the staging buffer. It then copies the merged 16 bits into the addressed half of tune_word, visible the cycle after the strobe. The other half keeps its value.
- R4: Address bit D9 selects the half-word (1 = bits 31..16, 0 = bits 15..0). D8 selects the byte in the buffer (1 = high byte, 0 = low byte). D11..D10 are not decoded. Every frequency write makes D9 the new pointer.
- R5: Direct write: the buffer keeps both bytes between commands. A lone 4'b0010 word replaces one byte and commits the buffer, using the byte left by the earlier write as its partner.
- R6: A committing write that addresses the other half-word from the previously buffered byte still lands in the half named by its own D9.
- R7: A valid word with D15..D14 = 2'b11 is a control word. It loads sleep_o from D13 and reset_o from D12 on the next cycle. D10..D0 have no effect.
- R8: A control word with D11 = 1 sets sync_o and selsrc_o to 1, and they stay set. clr_o is 1 for exactly the one cycle after that word and then returns to 0 with no further write.
- R9: While reset_o is 1, dac_code equals midscale (1 << (DAC_W-1)). Otherwise it equals dac_in.
- R10: Words with D15..D12 equal to 0000, 0001, 01xx or 10xx, and any word presented with cmd_valid low, leave tune_word, the buffer, the pointer and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous global reset |
| cmd_valid | input | 1 | Command word strobe, one cycle per word |
| cmd_word | input | 16 | Decoded command word, D15..D0 |
| dac_in | input | DAC_W | DAC code from the synthesis datapath |
| tune_word | output | 32 | Frequency tuning word |
| sleep_o | output | 1 | Sleep flag |
| reset_o | output | 1 | Reset flag |
| sync_o | output | 1 | Sync status, set by a clear request |
| selsrc_o | output | 1 | Register-select source status, set by a clear request |
| clr_o | output | 1 | Clear request, self-clearing after one cycle |
| dac_code | output | DAC_W | Reported DAC code, midscale while reset_o is 1 |

## Verification
Some rules are checked by assertions on every cycle, at the point where each decoded event meets a register. A staging write leaves the tuning word still. A commit puts the merged buffer into exactly the addressed half and leaves the other half alone. The pointer follows the last address. The clear request lasts one cycle, and its status bits rise right after it. The DAC code is forced to midscale while reset is set. Other properties need the bench's ordered scenarios: the full five-word programming sequence giving the expected 32-bit value, direct writes that depend on bytes left over from earlier commands, a commit across halves, and proof that ignored opcodes left the buffer alone, which shows only through a later commit.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int NUM_HALF = 2;
  localparam int TUNE_W  = NUM_HALF * HALF_W;
  localparam int CMD_W   = 16;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STAGE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_CTRL   = 2'd3
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              half_hi;
    logic              byte_hi;
    logic [BYTE_W-1:0] data;
    logic              sleep;
    logic              rst;
    logic              clr;
  } cmd_t;

  // Classify one command word; only the fields the opcode uses matter.
  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.half_hi = w[9];
    c.byte_hi = w[8];
    c.data    = w[7:0];
    c.sleep   = w[13];
    c.rst     = w[12];
    c.clr     = w[11];
    if (w[15:14] == 2'b11)       c.op = OP_CTRL;
    else if (w[15:12] == 4'b0011) c.op = OP_STAGE;
    else if (w[15:12] == 4'b0010) c.op = OP_COMMIT;
    else                          c.op = OP_NONE;
    return c;
  endfunction

  // Replace one byte of a half-word.
  function automatic logic [HALF_W-1:0] merge_byte(input logic [HALF_W-1:0] cur,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] d);
    return hi ? {d, cur[BYTE_W-1:0]} : {cur[HALF_W-1:BYTE_W], d};
  endfunction

  function automatic logic [31:0] midscale(input int w);
    return 32'd1 << (w - 1);
  endfunction
endpackage

// File: rtl/tw_decoder.sv
module tw_decoder
  import tw_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             stage_ev,
  output logic             commit_ev,
  output logic             ctrl_ev,
  output cmd_t             cmd
);
  always_comb begin
    cmd       = decode_cmd(cmd_word);
    stage_ev  = cmd_valid && (cmd.op == OP_STAGE);
    commit_ev = cmd_valid && (cmd.op == OP_COMMIT);
    ctrl_ev   = cmd_valid && (cmd.op == OP_CTRL);
  end
endmodule

// File: rtl/tw_defer_buf.sv
module tw_defer_buf
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              half_hi,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] data,
  output logic [HALF_W-1:0] merged,
  output logic [HALF_W-1:0] buf_q,
  output logic              ptr_q
);
  always_comb merged = merge_byte(buf_q, byte_hi, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      ptr_q <= 1'b0;
    end else if (wr_ev) begin
      buf_q <= merged;
      ptr_q <= half_hi;
    end
  end

  assert_ptr_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> ptr_q == $past(half_hi));
  assert_buf_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(buf_q));
endmodule

// File: rtl/tw_tune_reg.sv
module tw_tune_reg
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_ev,
  input  logic              half_sel,
  input  logic [HALF_W-1:0] commit_data,
  output logic [TUNE_W-1:0] tune_q
);
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tune_q[h*HALF_W +: HALF_W] <= '0;
      else if (commit_ev && (half_sel == h[0]))
        tune_q[h*HALF_W +: HALF_W] <= commit_data;
    end

    assert_commit_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ev && half_sel == h[0]) |=> tune_q[h*HALF_W +: HALF_W] == $past(commit_data));
    assert_other_half_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ev && half_sel != h[0]) |=> $stable(tune_q[h*HALF_W +: HALF_W]));
  end
endmodule

// File: rtl/tw_ctrl_reg.sv
module tw_ctrl_reg #(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_ev,
  input  logic             sleep_d,
  input  logic             rst_d,
  input  logic             clr_d,
  input  logic [DAC_W-1:0] dac_in,
  output logic             sleep_q,
  output logic             reset_q,
  output logic             sync_q,
  output logic             selsrc_q,
  output logic             clr_q,
  output logic [DAC_W-1:0] dac_code
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(tw_pkg::midscale(DAC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q  <= 1'b1;
      reset_q  <= 1'b1;
      sync_q   <= 1'b0;
      selsrc_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      clr_q <= ctrl_ev && clr_d;
      if (ctrl_ev) begin
        sleep_q <= sleep_d;
        reset_q <= rst_d;
        if (clr_d) begin
          sync_q   <= 1'b1;
          selsrc_q <= 1'b1;
        end
      end
    end
  end

  always_comb dac_code = reset_q ? MID : dac_in;

  assert_clr_self_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !ctrl_ev) |=> !clr_q);
  assert_clr_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (sync_q && selsrc_q));
  assert_midscale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_q |-> dac_code == MID);
  assert_flags_only_by_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ev |=> ($stable(sleep_q) && $stable(reset_q)));
endmodule

// File: rtl/tuning_word_if.sv
module tuning_word_if
  import tw_pkg::*;
#(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  input  logic [DAC_W-1:0] dac_in,
  output logic [31:0]      tune_word,
  output logic             sleep_o,
  output logic             reset_o,
  output logic             sync_o,
  output logic             selsrc_o,
  output logic             clr_o,
  output logic [DAC_W-1:0] dac_code
);
  logic              stage_ev, commit_ev, ctrl_ev, wr_ev;
  cmd_t              cmd;
  logic [HALF_W-1:0] merged, buf_q;
  logic              ptr_q;

  tw_decoder u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .stage_ev(stage_ev), .commit_ev(commit_ev), .ctrl_ev(ctrl_ev), .cmd(cmd)
  );

  assign wr_ev = stage_ev || commit_ev;

  tw_defer_buf u_buf (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev),
    .half_hi(cmd.half_hi), .byte_hi(cmd.byte_hi), .data(cmd.data),
    .merged(merged), .buf_q(buf_q), .ptr_q(ptr_q)
  );

  tw_tune_reg u_tune (
    .clk(clk), .rst_n(rst_n), .commit_ev(commit_ev),
    .half_sel(cmd.half_hi), .commit_data(merged), .tune_q(tune_word)
  );

  tw_ctrl_reg #(.DAC_W(DAC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_ev(ctrl_ev),
    .sleep_d(cmd.sleep), .rst_d(cmd.rst), .clr_d(cmd.clr), .dac_in(dac_in),
    .sleep_q(sleep_o), .reset_q(reset_o), .sync_q(sync_o), .selsrc_q(selsrc_o),
    .clr_q(clr_o), .dac_code(dac_code)
  );

  assert_stage_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_ev |=> $stable(tune_word));
  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(tune_word));
  assert_ptr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(ptr_q));
endmodule

// File: tb/sim_tuning_word_if.sv
module sim_tuning_word_if;
  localparam int DAC_W = 10;
  localparam logic [DAC_W-1:0] MID = 10'h200;
  localparam logic [DAC_W-1:0] RAW = 10'h155;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [DAC_W-1:0] dac_in = RAW;
  logic [31:0] tune_word;
  logic sleep_o, reset_o, sync_o, selsrc_o, clr_o;
  logic [DAC_W-1:0] dac_code;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tuning_word_if #(.DAC_W(DAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dac_in(dac_in), .tune_word(tune_word), .sleep_o(sleep_o), .reset_o(reset_o),
    .sync_o(sync_o), .selsrc_o(selsrc_o), .clr_o(clr_o), .dac_code(dac_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one word for one cycle; return at the negedge after the capturing edge.
  task automatic send(input logic [15:0] w, input logic v = 1'b1);
    @(negedge clk);
    cmd_valid = v;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic t_reset;
    check("R1 tune", tune_word, 32'h0);
    check("R1 sleep/reset", {sleep_o, reset_o}, 2'b11);
    check("R1 sync/selsrc/clr", {sync_o, selsrc_o, clr_o}, 3'b000);
    check("R9 midscale after reset", dac_code, MID);
    send(16'h2000);  // commit with empty buffer: byte 0 -> lower half stays 0
    check("R1 buffer zero", tune_word, 32'h0);
  endtask

  task automatic t_program;
    send(16'hF800);
    check("R8 clr pulse", clr_o, 1'b1);
    check("R8 sync/selsrc set", {sync_o, selsrc_o}, 2'b11);
    check("R7 sleep/reset set", {sleep_o, reset_o}, 2'b11);
    @(negedge clk);
    check("R8 clr self clears", clr_o, 1'b0);
    check("R8 status sticky", {sync_o, selsrc_o}, 2'b11);
    send(16'h3333);
    check("R2 stage no change", tune_word, 32'h0);
    send(16'h2233);
    check("R3 upper commit", tune_word, 32'h3333_0000);
    send(16'h3133);
    check("R2 stage no change lower", tune_word, 32'h3333_0000);
    send(16'h2033);
    check("R3 R4 full word", tune_word, 32'h3333_3333);
    send(16'hC000);
    check("R7 sleep/reset cleared", {sleep_o, reset_o}, 2'b00);
    check("R9 raw dac", dac_code, RAW);
  endtask

  task automatic t_direct;
    send(16'h2055);
    check("R5 direct low byte", tune_word, 32'h3333_3355);
    send(16'h2177);
    check("R5 direct high byte", tune_word, 32'h3333_7755);
    send(16'h2399);
    check("R6 cross half commit", tune_word, 32'h9955_7755);
  endtask

  task automatic t_ignored;
    send(16'h1234);
    send(16'h0312);
    send(16'h4FFF);
    send(16'h8BFF);
    send(16'h20AA, 1'b0);
    check("R10 tune unchanged", tune_word, 32'h9955_7755);
    check("R10 flags unchanged", {sleep_o, reset_o, sync_o, selsrc_o, clr_o}, 5'b00110);
    send(16'h2200);  // buffer must still hold 0x99 in the high byte
    check("R10 buffer untouched", tune_word, 32'h9900_7755);
  endtask

  task automatic t_ctrl;
    send(16'hE7FF);
    check("R7 dont care bits", {sleep_o, reset_o, clr_o}, 3'b100);
    check("R7 tune unchanged", tune_word, 32'h9900_7755);
    send(16'hD000);
    check("R9 midscale on reset", dac_code, MID);
    check("R7 reset only", {sleep_o, reset_o}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_direct();
    t_ignored();
    t_ctrl();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule